// File: doc/BRIEF.md
# Supply Fault Status Latch

This block keeps the supply-fault status of a motor driver's digital core. It takes three comparator flags and synchronizes them: the supply is under its rising threshold, the supply is under the level that resets the core, and the charge-pump rail is under its limit. From these it drives a live summary fault bit, two sticky cause bits, a bridge-disable line and the drive-low enable of an open-drain fault pin. Fault flags from other blocks also feed the summary bit and the pin, through a vector input.

The summary bit follows the live condition. The cause bits stay set until a clear-fault pulse or a sleep reset pulse arrives. Either pulse clears a cause bit only when its condition has gone away. While the supply is below the reset level, the core is held inert: every status bit is low, the pin is released, the bridges are off and the core reports that its registers are not reachable. When the supply rises out of the reset level but is still under the rising threshold, the summary bit is set and the undervoltage cause bit is not.

Top module: `supply_fault_latch`

## Requirements
- R1: After `rst_n` is released with all inputs idle, within four cycles `fault_o`, `uvlo_o`, `cpuv_o`, `bridge_off_o` and `fault_pin_pull_o` are 0 and `core_live_o` is 1.
- R2: A rising supply-undervoltage flag, seen while the core is live, sets `fault_o`, `uvlo_o` and `bridge_off_o` to 1.
- R3: When the supply-undervoltage flag returns to 0, `fault_o` and `bridge_off_o` return to 0 and `uvlo_o` stays 1.
- R4: A one-cycle `clr_fault_i` pulse clears `uvlo_o` or `cpuv_o` only if that bit's condition is absent. A bit whose condition is still present stays 1.
- R5: A one-cycle `sleep_rst_i` pulse has the same clearing effect as `clr_fault_i`.
- R6: While the reset-level flag is 1, `fault_o`, `uvlo_o`, `cpuv_o`, `fault_pin_pull_o` and `core_live_o` are 0 and `bridge_off_o` is 1. This overrides every other input, including the clear pulses.
- R7: When the reset-level flag drops while the undervoltage flag is still 1, `fault_o` becomes 1 and `uvlo_o` stays 0.
- R8: A charge-pump undervoltage flag sets `fault_o`, `cpuv_o` and `bridge_off_o`. When the flag clears, `fault_o` and `bridge_off_o` clear and `cpuv_o` stays 1.
- R9: Any bit of `ext_fault_i` sets `fault_o` and `fault_pin_pull_o` one cycle later. It does not set `bridge_off_o` and leaves no sticky bit.
- R10: `fault_pin_pull_o` (1 = pin pulled low) equals `fault_o` in every cycle.
- R11: Comparator inputs reach the outputs `SYNC_STAGES`+1 cycles after they change, which is 3 cycles by default. Clear pulses and external faults take 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous core reset |
| uv_cmp_i | input | 1 | Supply below rising threshold (asynchronous) |
| rst_lvl_cmp_i | input | 1 | Supply below core reset level (asynchronous) |
| cp_uv_cmp_i | input | 1 | Charge-pump rail under limit (asynchronous) |
| ext_fault_i | input | N_EXT | Live fault flags from other blocks |
| clr_fault_i | input | 1 | Clear-fault command, one-cycle pulse |
| sleep_rst_i | input | 1 | Sleep reset pulse, one cycle |
| fault_o | output | 1 | Live summary fault bit |
| uvlo_o | output | 1 | Sticky supply-undervoltage cause |
| cpuv_o | output | 1 | Sticky charge-pump undervoltage cause |
| bridge_off_o | output | 1 | Disables all bridge outputs |
| fault_pin_pull_o | output | 1 | Open-drain fault pin drive-low enable |
| core_live_o | output | 1 | Core out of reset level, registers reachable |

## Verification
Directed steps put each supply event in order: undervoltage entry and exit, a clear while the condition holds and a clear after it has gone, charge-pump entry and exit, external faults, and entry to and exit from the reset level with undervoltage still present. These steps separate the edge-triggered undervoltage cause from the level-triggered charge-pump cause, and separate the live summary from the sticky bits. A random phase with a fixed seed toggles all inputs with held intervals, including clear pulses during the reset level and events that overlap. The outputs are compared every cycle against a bench model with the stated latency, which exposes wrong latency and wrong priority between set, clear and the reset level.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
   // comparator bundle after synchronisation
   typedef struct packed {
      logic uv;
      logic rst_lvl;
      logic cp;
   } sfl_cmp_t;

   localparam int SFL_CMP_W = $bits(sfl_cmp_t);

   // sticky cell variants
   typedef enum logic [0:0] {
      STICKY_LEVEL = 1'b0,
      STICKY_EDGE  = 1'b1
   } sfl_sticky_mode_e;
endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("sfl_sync: W must be at least 1");
   end
   if (STAGES == 1) begin : g_bad_stages
      $error("sfl_sync: STAGES must be 0 or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
      assign q_o = stg_q[STAGES-1];
   end
endmodule

// File: rtl/sfl_sticky.sv
module sfl_sticky
   import sfl_pkg::*;
#(
   parameter sfl_sticky_mode_e MODE = STICKY_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond_i,   // live condition
   input  logic blank_i,  // core held at reset level
   input  logic clr_i,    // clear request
   output logic flag_o
);
   logic set_w;
   logic flag_q;

   if (MODE == STICKY_EDGE) begin : g_edge
      logic prev_q;
      // while blanked the history is forced high so that leaving the
      // reset level with the condition present does not count as an edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       prev_q <= 1'b0;
         else if (blank_i) prev_q <= 1'b1;
         else              prev_q <= cond_i;
      end
      assign set_w = cond_i & ~prev_q;
   end else begin : g_level
      assign set_w = cond_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flag_q <= 1'b0;
      else if (blank_i)            flag_q <= 1'b0;
      else if (set_w)              flag_q <= 1'b1;
      else if (clr_i && !cond_i)   flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/sfl_summary.sv
module sfl_summary #(
   parameter int N_EXT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uv_i,
   input  logic             cp_i,
   input  logic             blank_i,
   input  logic [N_EXT-1:0] ext_i,
   output logic             fault_o,
   output logic             bridge_off_o,
   output logic             live_o
);
   if (N_EXT < 1) begin : g_bad_ext
      $error("sfl_summary: N_EXT must be at least 1");
   end

   logic supply_bad_w;
   logic fault_q, off_q, live_q;

   assign supply_bad_w = uv_i | cp_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         off_q   <= 1'b1;
         live_q  <= 1'b0;
      end else if (blank_i) begin
         fault_q <= 1'b0;
         off_q   <= 1'b1;
         live_q  <= 1'b0;
      end else begin
         fault_q <= supply_bad_w | (|ext_i);
         off_q   <= supply_bad_w;
         live_q  <= 1'b1;
      end
   end

   assign fault_o      = fault_q;
   assign bridge_off_o = off_q;
   assign live_o       = live_q;
endmodule

// File: rtl/supply_fault_latch.sv
module supply_fault_latch
   import sfl_pkg::*;
#(
   parameter int N_EXT       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uv_cmp_i,
   input  logic             rst_lvl_cmp_i,
   input  logic             cp_uv_cmp_i,
   input  logic [N_EXT-1:0] ext_fault_i,
   input  logic             clr_fault_i,
   input  logic             sleep_rst_i,
   output logic             fault_o,
   output logic             uvlo_o,
   output logic             cpuv_o,
   output logic             bridge_off_o,
   output logic             fault_pin_pull_o,
   output logic             core_live_o
);
   sfl_cmp_t cmp_raw, cmp_s;
   logic     clr_any;

   assign cmp_raw = '{uv: uv_cmp_i, rst_lvl: rst_lvl_cmp_i, cp: cp_uv_cmp_i};
   assign clr_any = clr_fault_i | sleep_rst_i;

   sfl_sync #(.W(SFL_CMP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_raw),
      .q_o   (cmp_s)
   );

   sfl_sticky #(.MODE(STICKY_EDGE)) u_uvlo (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond_i  (cmp_s.uv),
      .blank_i (cmp_s.rst_lvl),
      .clr_i   (clr_any),
      .flag_o  (uvlo_o)
   );

   sfl_sticky #(.MODE(STICKY_LEVEL)) u_cpuv (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond_i  (cmp_s.cp),
      .blank_i (cmp_s.rst_lvl),
      .clr_i   (clr_any),
      .flag_o  (cpuv_o)
   );

   sfl_summary #(.N_EXT(N_EXT)) u_sum (
      .clk          (clk),
      .rst_n        (rst_n),
      .uv_i         (cmp_s.uv),
      .cp_i         (cmp_s.cp),
      .blank_i      (cmp_s.rst_lvl),
      .ext_i        (ext_fault_i),
      .fault_o      (fault_o),
      .bridge_off_o (bridge_off_o),
      .live_o       (core_live_o)
   );

   // open-drain pin: drive low whenever the summary bit is set
   assign fault_pin_pull_o = fault_o;
endmodule

// File: rtl/sfl_checker.sv
module sfl_checker #(
   parameter int N_EXT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             s_uv,
   input logic             s_rst,
   input logic             s_cp,
   input logic             clr_any,
   input logic [N_EXT-1:0] ext_fault_i,
   input logic             fault_o,
   input logic             uvlo_o,
   input logic             cpuv_o,
   input logic             bridge_off_o,
   input logic             fault_pin_pull_o,
   input logic             core_live_o
);
   p_rst_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s_rst |=> (!fault_o && !uvlo_o && !cpuv_o && bridge_off_o && !core_live_o));

   p_uv_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_uv && !s_rst) |=> (fault_o && bridge_off_o));

   p_uvlo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (uvlo_o && !s_rst && !clr_any) |=> uvlo_o);

   p_cpuv_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_cp && !s_rst) |=> (cpuv_o && fault_o));

   p_clear_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_any && s_cp && !s_rst) |=> cpuv_o);

   p_ext_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ext_fault_i) && !s_rst) |=> fault_pin_pull_o);

   p_pin_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !core_live_o |-> !fault_pin_pull_o);
endmodule

bind supply_fault_latch sfl_checker #(.N_EXT(N_EXT)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .s_uv             (cmp_s.uv),
   .s_rst            (cmp_s.rst_lvl),
   .s_cp             (cmp_s.cp),
   .clr_any          (clr_any),
   .ext_fault_i      (ext_fault_i),
   .fault_o          (fault_o),
   .uvlo_o           (uvlo_o),
   .cpuv_o           (cpuv_o),
   .bridge_off_o     (bridge_off_o),
   .fault_pin_pull_o (fault_pin_pull_o),
   .core_live_o      (core_live_o)
);

// File: tb/supply_fault_latch_tb.sv
module supply_fault_latch_tb_top;
   localparam int N_EXT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uv = 1'b0, rl = 1'b0, cp = 1'b0;
   logic [N_EXT-1:0] ext = '0;
   logic clr = 1'b0, slp = 1'b0;
   logic fault, uvlo, cpuv, boff, pin, live;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   supply_fault_latch #(.N_EXT(N_EXT), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .uv_cmp_i(uv), .rst_lvl_cmp_i(rl), .cp_uv_cmp_i(cp),
      .ext_fault_i(ext), .clr_fault_i(clr), .sleep_rst_i(slp),
      .fault_o(fault), .uvlo_o(uvlo), .cpuv_o(cpuv),
      .bridge_off_o(boff), .fault_pin_pull_o(pin), .core_live_o(live)
   );

   // ---- bench model built from the requirements (R11 latency) ----
   logic [2:0] m_d1, m_d2;      // {uv, rl, cp} delayed SYNC_STAGES cycles
   logic m_prev, m_fault, m_uvlo, m_cpuv, m_off, m_live;

   function automatic logic uvlo_next(logic cur, logic c, logic prev, logic blank, logic clr_req);
      if (blank)               return 1'b0;
      if (c && !prev)          return 1'b1;
      if (clr_req && !c)       return 1'b0;
      return cur;
   endfunction

   function automatic logic cpuv_next(logic cur, logic c, logic blank, logic clr_req);
      if (blank)               return 1'b0;
      if (c)                   return 1'b1;
      if (clr_req)             return 1'b0;
      return cur;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_d1 <= '0; m_d2 <= '0; m_prev <= 1'b0;
         m_fault <= 1'b0; m_uvlo <= 1'b0; m_cpuv <= 1'b0;
         m_off <= 1'b1; m_live <= 1'b0;
      end else begin
         m_d1 <= {uv, rl, cp};
         m_d2 <= m_d1;
         m_uvlo <= uvlo_next(m_uvlo, m_d2[2], m_prev, m_d2[1], clr | slp);
         m_cpuv <= cpuv_next(m_cpuv, m_d2[0], m_d2[1], clr | slp);
         m_prev <= m_d2[1] ? 1'b1 : m_d2[2];
         m_fault <= m_d2[1] ? 1'b0 : (m_d2[2] | m_d2[0] | (|ext));
         m_off   <= m_d2[1] ? 1'b1 : (m_d2[2] | m_d2[0]);
         m_live  <= ~m_d2[1];
      end
   end

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2/R3 fault_o model", fault, m_fault);
         chk("R4/R7 uvlo_o model", uvlo, m_uvlo);
         chk("R5/R8 cpuv_o model", cpuv, m_cpuv);
         chk("R6 bridge_off_o model", boff, m_off);
         chk("R6 core_live_o model", live, m_live);
         chk("R10 pin follows fault", pin, fault);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_clr();
      clr = 1'b1; @(negedge clk); clr = 1'b0;
   endtask

   task automatic pulse_slp();
      slp = 1'b1; @(negedge clk); slp = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      step(3);
      rst_n = 1'b1;
      step(4);
      // R1 reset state
      chk("R1 fault", fault, 1'b0); chk("R1 uvlo", uvlo, 1'b0);
      chk("R1 cpuv", cpuv, 1'b0);   chk("R1 bridge_off", boff, 1'b0);
      chk("R1 pin", pin, 1'b0);     chk("R1 live", live, 1'b1);

      // R2 / R11 undervoltage entry with latency
      uv = 1'b1; step(2);
      chk("R11 fault not yet", fault, 1'b0);
      step(1);
      chk("R2 fault", fault, 1'b1); chk("R2 uvlo", uvlo, 1'b1);
      chk("R2 bridge_off", boff, 1'b1); chk("R10 pin", pin, 1'b1);
      // R4 clear blocked while condition present
      pulse_clr();
      chk("R4 uvlo kept", uvlo, 1'b1);
      // R3 recovery
      uv = 1'b0; step(3);
      chk("R3 fault", fault, 1'b0); chk("R3 bridge_off", boff, 1'b0);
      chk("R3 uvlo sticky", uvlo, 1'b1);
      pulse_clr();
      chk("R4 uvlo cleared", uvlo, 1'b0);

      // R8 charge pump
      cp = 1'b1; step(3);
      chk("R8 fault", fault, 1'b1); chk("R8 cpuv", cpuv, 1'b1);
      chk("R8 bridge_off", boff, 1'b1);
      pulse_slp();
      chk("R5 cpuv kept", cpuv, 1'b1);
      cp = 1'b0; step(3);
      chk("R8 fault clear", fault, 1'b0); chk("R8 cpuv sticky", cpuv, 1'b1);
      pulse_slp();
      chk("R5 cpuv cleared", cpuv, 1'b0);

      // R9 external faults
      ext = 4'b0100; step(1);
      chk("R9 fault", fault, 1'b1); chk("R9 pin", pin, 1'b1);
      chk("R9 bridge_off", boff, 1'b0);
      ext = '0; step(1);
      chk("R9 fault drop", fault, 1'b0);
      chk("R9 no sticky", uvlo | cpuv, 1'b0);

      // R6 reset level overrides
      uv = 1'b1; cp = 1'b1; step(3);
      rl = 1'b1; step(3);
      chk("R6 fault", fault, 1'b0); chk("R6 uvlo", uvlo, 1'b0);
      chk("R6 cpuv", cpuv, 1'b0);   chk("R6 pin", pin, 1'b0);
      chk("R6 live", live, 1'b0);   chk("R6 bridge_off", boff, 1'b1);
      cp = 1'b0; step(3);
      pulse_clr();
      chk("R6 clr ignored", fault | uvlo, 1'b0);

      // R7 power-up with undervoltage still present
      rl = 1'b0; step(3);
      chk("R7 fault", fault, 1'b1); chk("R7 uvlo", uvlo, 1'b0);
      chk("R7 live", live, 1'b1);
      uv = 1'b0; step(3);
      chk("R7 recover", fault | uvlo, 1'b0);

      // random phase
      for (int c = 0; c < 4000; c++) begin
         if ($urandom % 9 == 0)  uv = ~uv;
         if ($urandom % 11 == 0) cp = ~cp;
         if ($urandom % 40 == 0) rl = ~rl;
         ext = ($urandom % 6 == 0) ? N_EXT'($urandom) : '0;
         clr = ($urandom % 12 == 0);
         slp = ($urandom % 20 == 0);
         step(1);
      end
      clr = 1'b0; slp = 1'b0;
      step(4);
      finish_run();
   end
endmodule